// File: doc/BRIEF.md
# Prime-Modulus Chained Hash Address Generator

This block turns a stream of 8-bit symbols into addresses for a 4096-entry lookup table. Each symbol is joined with a 12-bit history code, the symbol taking the upper bits, to form a 20-bit hash argument. That argument is reduced modulo the prime 4021, and the remainder is the table address. The 12-bit word stored at that address becomes the history code for the next symbol. Chained this way, each address depends on the symbol and on everything that came before it.

The remainder comes from a restoring shift-and-subtract loop that takes in one argument bit per clock. A new symbol is taken through a valid/ready handshake. The address leaves on a one-cycle valid pulse, and a read request with the same address goes out at the same moment. The table word comes back one cycle later on a synchronous read port and becomes the new history. Because the modulus is below the table size, table locations 4021 to 4095 are never addressed.

Top module: `hash_chain_mod`

## Requirements
- R1: For each accepted symbol S with history H, the address output equals ({S,H} as a 20-bit value, S in bits 19..12) modulo 4021.
- R2: Every address presented with out_valid high is at most 4020.
- R3: For the first symbol accepted after reset, H is the symbol itself zero-extended to 12 bits.
- R4: For every later symbol, H is the 12-bit word that mem_rdata returned for the previous symbol's address.
- R5: A symbol is taken only at a rising edge where in_valid and in_ready are both high. in_ready is low for exactly 22 clock cycles after that edge. A valid symbol offered while in_ready is low is ignored and changes no later address.
- R6: out_valid is high for exactly one cycle per accepted symbol, in the 21st cycle after the accepting edge (after 20 reduction steps).
- R7: mem_rd is high in the same cycle as out_valid and mem_addr equals out_addr then. mem_rdata is sampled one cycle after the request.
- R8: During and directly after reset, in_ready is high and out_valid and mem_rd are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Symbol offered |
| in_sym | input | 8 | Symbol value |
| in_ready | output | 1 | Block can take a symbol |
| out_valid | output | 1 | One-cycle address strobe |
| out_addr | output | 12 | Hash address (remainder) |
| mem_rd | output | 1 | Table read request |
| mem_addr | output | 12 | Table read address |
| mem_rdata | input | 12 | Table word, valid one cycle after mem_rd |

## Verification
Two events can meet in the same cycle: the table word arriving and becoming the new history, and the next symbol being taken. The bench provokes this by holding in_valid high across whole runs of symbols, so each new symbol is taken on the first edge after the capture. A stale history would then show up as a wrong address. The bench also offers a symbol while the block is busy, and explicit table entries steer the chain to remainders of 0, 4020 and an exact multiple of 4021. A behavioural model, checked every clock, compares the handshake, the pulse timing and each remainder.

// File: rtl/hash_chain_pkg.sv
package hash_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LOAD = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/rem_reducer.sv
// Restoring remainder: one argument bit per cycle, MSB first.
module rem_reducer #(
  parameter int ARG_W   = 20,
  parameter int OUT_W   = 12,
  parameter int MODULUS = 4021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ARG_W-1:0] arg,
  output logic             done,
  output logic [OUT_W-1:0] rem
);
  localparam int RW    = OUT_W + 1;
  localparam int CNT_W = $clog2(ARG_W + 1);
  localparam logic [RW-1:0] MOD_V = RW'(MODULUS);

  logic [ARG_W-1:0] sh_q;
  logic [OUT_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  logic [RW-1:0]    trial;
  logic [RW-1:0]    diff;
  logic             ge;

  always_comb begin
    trial = {rem_q, sh_q[ARG_W-1]};
    diff  = trial - MOD_V;
    ge    = (trial >= MOD_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        sh_q   <= arg;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(ARG_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sh_q  <= sh_q << 1;
        rem_q <= ge ? diff[OUT_W-1:0] : trial[OUT_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign rem  = rem_q;
endmodule

// File: rtl/chain_ctl.sv
// Handshake, history register and sequencing.
module chain_ctl
  import hash_chain_pkg::*;
#(
  parameter int SYM_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [SYM_W-1:0]          in_sym,
  input  logic                      done,
  input  logic [CODE_W-1:0]         mem_rdata,
  output logic                      in_ready,
  output logic                      start,
  output logic [SYM_W+CODE_W-1:0]   arg
);
  ctl_state_t        state_q;
  logic              first_q;
  logic [CODE_W-1:0] prev_q;
  logic [CODE_W-1:0] seed;

  always_comb begin
    in_ready = (state_q == ST_IDLE);
    start    = in_valid && in_ready;
    seed     = first_q ? CODE_W'(in_sym) : prev_q;
    arg      = {in_sym, seed};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      first_q <= 1'b1;
      prev_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          first_q <= 1'b0;
        end
        ST_RUN:  if (done) state_q <= ST_LOAD;
        ST_LOAD: begin
          prev_q  <= mem_rdata;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hash_chain_mod.sv
module hash_chain_mod #(
  parameter int SYM_W   = 8,
  parameter int CODE_W  = 12,
  parameter int MODULUS = 4021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SYM_W-1:0]  in_sym,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_addr,
  output logic              mem_rd,
  output logic [CODE_W-1:0] mem_addr,
  input  logic [CODE_W-1:0] mem_rdata
);
  localparam int ARG_W = SYM_W + CODE_W;

  logic             start;
  logic             done;
  logic [ARG_W-1:0] arg;
  logic [CODE_W-1:0] rem;

  chain_ctl #(.SYM_W(SYM_W), .CODE_W(CODE_W)) u_ctl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
    .done(done), .mem_rdata(mem_rdata), .in_ready(in_ready),
    .start(start), .arg(arg)
  );

  rem_reducer #(.ARG_W(ARG_W), .OUT_W(CODE_W), .MODULUS(MODULUS)) u_red (
    .clk(clk), .rst(rst), .start(start), .arg(arg),
    .done(done), .rem(rem)
  );

  assign out_valid = done;
  assign out_addr  = rem;
  assign mem_rd    = done;
  assign mem_addr  = rem;
endmodule

// File: rtl/hash_chain_mod_chk.sv
module hash_chain_mod_chk #(
  parameter int CODE_W  = 12,
  parameter int MODULUS = 4021
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_addr,
  input logic              mem_rd
);
  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr < CODE_W'(MODULUS)));
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R5
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R5
  busy_on_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  // R8
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_valid && !mem_rd));
endmodule

bind hash_chain_mod hash_chain_mod_chk #(.CODE_W(CODE_W), .MODULUS(MODULUS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_addr(out_addr), .mem_rd(mem_rd)
);

// File: tb/hash_chain_mod_tb.sv
`timescale 1ns/1ps
module hash_chain_mod_tb;
  localparam int MODV = 4021;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_sym = '0;
  logic        in_ready, out_valid, mem_rd;
  logic [11:0] out_addr, mem_addr;
  logic [11:0] mem_rdata = '0;

  logic [11:0] tbl [4096];

  int checks = 0;
  int errors = 0;
  int since = -1;
  bit first_m = 1'b1;
  int prev_m = 0;
  int exp_addr = 0;
  bit exp_first = 1'b0;
  int cycles = 0;
  bit done_run = 1'b0;

  always #10 clk = ~clk;

  hash_chain_mod u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
    .in_ready(in_ready), .out_valid(out_valid), .out_addr(out_addr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= tbl[mem_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model, compared on every falling edge.
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      since = -1;
      first_m = 1'b1;
    end else begin
      if (since >= 0) since++;
      if (since == 23) since = -1;
      chk(in_ready == (since < 0), "R5 in_ready", in_ready, since < 0);
      chk(out_valid == (since == 21), "R6 out_valid", out_valid, since == 21);
      chk(mem_rd == (since == 21), "R7 mem_rd", mem_rd, since == 21);
      if (since == 21) begin
        chk(out_addr == exp_addr, exp_first ? "R3 first addr" : "R1 R4 addr",
            out_addr, exp_addr);
        chk(out_addr < MODV, "R2 range", out_addr, MODV - 1);
        chk(mem_addr == out_addr, "R7 mem_addr", mem_addr, out_addr);
      end
      if (since < 0 && in_valid) begin
        int h;
        int harg;
        h = first_m ? int'(in_sym) : prev_m;
        harg = int'(in_sym) * 4096 + h;
        exp_first = first_m;
        exp_addr = harg % MODV;
        prev_m = tbl[exp_addr];
        first_m = 1'b0;
        since = 0;
      end
    end
  end

  task automatic send(input logic [7:0] s, input bit keep);
    in_sym = s;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    if (!keep) in_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) tbl[i] = 12'((i * 1103 + 517) % 4096);
    tbl[0]    = 12'd4020;
    tbl[4020] = 12'd4021;
    repeat (3) @(posedge clk);
    #2;
    // R8: state held during reset
    chk(in_ready === 1'b1, "R8 ready in reset", in_ready, 1);
    chk(out_valid === 1'b0, "R8 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && mem_rd === 1'b0,
        "R8 after reset", {in_ready, out_valid, mem_rd}, 3'b100);
    @(posedge clk); #2;
    // R3 first symbol zero -> 0; chain to 4020 then exact multiple -> 0
    send(8'd0, 0);
    send(8'd0, 0);
    send(8'd0, 0);
    send(8'd255, 0);
    drain();
    // R5: offer while busy, must be ignored
    send(8'd17, 0);
    repeat (3) @(posedge clk);
    #2;
    in_sym = 8'hEE; in_valid = 1'b1;
    repeat (5) @(posedge clk);
    #2; in_valid = 1'b0;
    drain();
    // R4: back-to-back stream, valid held high
    for (int i = 0; i < 60; i++) send(8'($urandom_range(0, 255)), 1);
    in_valid = 1'b0;
    drain();
    // R3 again after a second reset
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2; rst = 1'b0;
    send(8'hAB, 0);
    for (int i = 0; i < 120; i++) begin
      send(8'($urandom_range(0, 255)), (i % 3) != 0);
      if ((i % 7) == 0) repeat (2) @(posedge clk);
    end
    in_valid = 1'b0;
    drain();
    repeat (4) @(posedge clk);
    done_run = 1'b1;
  end

  initial begin
    wait (done_run || cycles > 150000);
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule